// File: doc/BRIEF.md
# Four-Bank DRAM Command Scheduler

This block turns memory transactions into DRAM commands for four banks that share one command/address bus. Each bank has its own request port carrying one transaction at a time: a read or write flag, a row address and a column address, qualified by a valid/ready pair. A per-bank controller remembers whether its bank is closed or holds an open row, and which row that is. From this it works out the next command that the transaction at its port needs: an activate, a precharge, a read or a write.

Every cycle a shared arbiter scores the command that each bank has pending and puts at most one command on the bus. The score rewards waiting time, so a bank that has been held back by timing or by losing arbitration gains priority. A bank whose command may not yet legally issue scores nothing. A transaction is accepted in the cycle its read or write issues. After that the row stays open, so later accesses to the same row need only one command.

Top module: `dram_cmd_sched`

## Requirements
- R1: A request to a bank with no open row produces ACTIVATE carrying the request row, followed later by READ (req_write=0) or WRITE (req_write=1) carrying the request column.
- R2: A request to the row already open in its bank produces a single READ or WRITE, with no ACTIVATE or PRECHARGE.
- R3: A request to a bank holding a different open row produces PRECHARGE, then ACTIVATE for the new row, then READ or WRITE, in that order.
- R4: A READ or WRITE to a bank issues no earlier than T_RCD cycles after that bank's ACTIVATE. With no competing bank it issues exactly T_RCD cycles after.
- R5: An ACTIVATE to a bank issues no earlier than T_RP cycles after that bank's PRECHARGE. With no competing bank it issues exactly T_RP cycles after.
- R6: A PRECHARGE to a bank issues no earlier than T_RAS cycles after that bank's last ACTIVATE. While it waits, no command issues from that bank.
- R7: Among banks whose pending command may legally issue, the one that has waited longest wins. Waiting time counts the cycles since the bank last issued while a request is present (saturating at 2^AGE_W-1). A bank that may not issue is never chosen, even when it is older.
- R8: When the highest waiting times are equal, the lowest-numbered bank wins.
- R9: req_ready[b] is high only in the cycle in which bank b issues READ or WRITE for its current request, and never while ACTIVATE or PRECHARGE issues. The row stays open afterwards.
- R10: After reset all banks are closed, the bus carries NOP, and no req_ready bit is high while no request is presented.
- R11: At most one command issues per cycle. The cmd_op encoding is 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE. cmd_bank names the issuing bank, cmd_row is valid with ACTIVATE, and cmd_col is valid with READ and WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_BANKS | Per-bank request present |
| req_write | input | N_BANKS | Per-bank request is a write |
| req_row | input | N_BANKS*ROW_W | Per-bank row address, bank b at bits [b*ROW_W +: ROW_W] |
| req_col | input | N_BANKS*COL_W | Per-bank column address, bank b at bits [b*COL_W +: COL_W] |
| req_ready | output | N_BANKS | Per-bank request accepted this cycle |
| cmd_op | output | 3 | Command issued this cycle |
| cmd_bank | output | log2(N_BANKS) | Bank addressed by the command |
| cmd_row | output | ROW_W | Row address for ACTIVATE |
| cmd_col | output | COL_W | Column address for READ/WRITE |

## Verification
The bench builds the block with T_RCD=2, T_RP=3 and T_RAS=5. Because the three delays differ, a counter loaded from the wrong parameter, or off by one, shows up as a command that moves by a cycle. The activate-to-precharge window of five cycles is long enough for a blocked bank to build a waiting time of two, so its score of three beats a freshly arrived lower-numbered bank. That makes age-over-index priority observable at the bus, next to the plain tie case between two idle banks.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;
endpackage

// File: rtl/dcs_bank.sv
module dcs_bank
    import dcs_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 7,
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic             grant,
    output cmd_e             pend_cmd,
    output logic             can_issue,
    output logic [AGE_W-1:0] age,
    output logic             done
);
    localparam int T_MAX1 = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int T_MAX  = (T_MAX1 > T_RAS) ? T_MAX1 : T_RAS;
    localparam int TMR_W  = $clog2(T_MAX + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [TMR_W-1:0] rcd;
        logic [TMR_W-1:0] rp;
        logic [TMR_W-1:0] ras;
        logic [AGE_W-1:0] age;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        pend_cmd  = CMD_NOP;
        can_issue = 1'b0;

        if (st_q.rcd != '0) st_d.rcd = st_q.rcd - 1'b1;
        if (st_q.rp  != '0) st_d.rp  = st_q.rp  - 1'b1;
        if (st_q.ras != '0) st_d.ras = st_q.ras - 1'b1;

        if (req_valid) begin
            if (!st_q.open) begin
                pend_cmd  = CMD_ACT;
                can_issue = (st_q.rp == '0);
            end else if (st_q.row == req_row) begin
                pend_cmd  = req_write ? CMD_WR : CMD_RD;
                can_issue = (st_q.rcd == '0);
            end else begin
                pend_cmd  = CMD_PRE;
                can_issue = (st_q.ras == '0);
            end
        end

        if (grant)
            st_d.age = '0;
        else if (req_valid)
            st_d.age = (st_q.age == AGE_MAX) ? AGE_MAX : st_q.age + 1'b1;
        else
            st_d.age = '0;

        if (grant && pend_cmd == CMD_ACT) begin
            st_d.open = 1'b1;
            st_d.row  = req_row;
            st_d.rcd  = TMR_W'(T_RCD - 1);
            st_d.ras  = TMR_W'(T_RAS - 1);
        end
        if (grant && pend_cmd == CMD_PRE) begin
            st_d.open = 1'b0;
            st_d.rp   = TMR_W'(T_RP - 1);
        end

        done = grant && (pend_cmd == CMD_RD || pend_cmd == CMD_WR);
        age  = st_q.age;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dcs_arbiter.sv
module dcs_arbiter #(
    parameter int N_BANKS = 4,
    parameter int AGE_W   = 8,
    localparam int BW     = $clog2(N_BANKS),
    localparam int SCORE_W = AGE_W + 1
) (
    input  logic [N_BANKS-1:0]       can_issue,
    input  logic [N_BANKS*AGE_W-1:0] ages,
    output logic [N_BANKS-1:0]       grant,
    output logic [BW-1:0]            win_idx
);
    logic [SCORE_W-1:0] score [N_BANKS];
    logic [SCORE_W-1:0] best;

    always_comb begin
        for (int i = 0; i < N_BANKS; i++)
            score[i] = can_issue[i]
                     ? {1'b0, ages[i*AGE_W +: AGE_W]} + 1'b1 : '0;
        best    = '0;
        win_idx = '0;
        // strict compare: on equal scores the earlier (lower) bank is kept
        for (int i = 0; i < N_BANKS; i++) begin
            if (score[i] > best) begin
                best    = score[i];
                win_idx = BW'(i);
            end
        end
        for (int i = 0; i < N_BANKS; i++)
            grant[i] = (best != '0) && (win_idx == BW'(i));
    end
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
    import dcs_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 6,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RAS   = 7,
    parameter int AGE_W   = 8,
    localparam int BW     = $clog2(N_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_BANKS-1:0]         req_valid,
    input  logic [N_BANKS-1:0]         req_write,
    input  logic [N_BANKS*ROW_W-1:0]   req_row,
    input  logic [N_BANKS*COL_W-1:0]   req_col,
    output logic [N_BANKS-1:0]         req_ready,
    output logic [2:0]                 cmd_op,
    output logic [BW-1:0]              cmd_bank,
    output logic [ROW_W-1:0]           cmd_row,
    output logic [COL_W-1:0]           cmd_col
);
    cmd_e                     pend [N_BANKS];
    logic [N_BANKS-1:0]       can_issue;
    logic [N_BANKS-1:0]       grant;
    logic [N_BANKS*AGE_W-1:0] ages;
    logic [BW-1:0]            win_idx;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        dcs_bank #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP),
            .T_RAS(T_RAS), .AGE_W(AGE_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[b]),
            .req_write (req_write[b]),
            .req_row   (req_row[b*ROW_W +: ROW_W]),
            .grant     (grant[b]),
            .pend_cmd  (pend[b]),
            .can_issue (can_issue[b]),
            .age       (ages[b*AGE_W +: AGE_W]),
            .done      (req_ready[b])
        );
    end

    dcs_arbiter #(.N_BANKS(N_BANKS), .AGE_W(AGE_W)) u_arb (
        .can_issue (can_issue),
        .ages      (ages),
        .grant     (grant),
        .win_idx   (win_idx)
    );

    always_comb begin
        cmd_op   = CMD_NOP;
        cmd_bank = '0;
        cmd_row  = '0;
        cmd_col  = '0;
        if (grant != '0) begin
            cmd_op   = pend[win_idx];
            cmd_bank = win_idx;
            cmd_row  = req_row[win_idx*ROW_W +: ROW_W];
            cmd_col  = req_col[win_idx*COL_W +: COL_W];
        end
    end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
    parameter int N_BANKS = 4,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RAS   = 7,
    localparam int BW     = $clog2(N_BANKS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_BANKS-1:0] req_ready,
    input logic [2:0]         cmd_op,
    input logic [BW-1:0]      cmd_bank
);
    localparam logic [7:0] CNT_MAX = 8'hFF;

    // R11
    ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    // R9
    ready_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |-> (cmd_op == 3'd2 || cmd_op == 3'd3));

    // R9
    ready_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |-> req_ready[cmd_bank]);

    for (genvar b = 0; b < N_BANKS; b++) begin : g_tm
        logic [7:0] since_act_q, since_pre_q;
        logic       hit;
        assign hit = (cmd_bank == BW'(b)) && (cmd_op != 3'd0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                since_act_q <= CNT_MAX;
                since_pre_q <= CNT_MAX;
            end else begin
                since_act_q <= (hit && cmd_op == 3'd1) ? 8'd1
                             : (since_act_q == CNT_MAX) ? CNT_MAX : since_act_q + 8'd1;
                since_pre_q <= (hit && cmd_op == 3'd4) ? 8'd1
                             : (since_pre_q == CNT_MAX) ? CNT_MAX : since_pre_q + 8'd1;
            end
        end

        // R4
        act_to_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && (cmd_op == 3'd2 || cmd_op == 3'd3)) |-> (since_act_q >= 8'(T_RCD)));

        // R5
        pre_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && cmd_op == 3'd1) |-> (since_pre_q >= 8'(T_RP)));

        // R6
        act_to_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && cmd_op == 3'd4) |-> (since_act_q >= 8'(T_RAS)));
    end
endmodule

bind dram_cmd_sched dcs_checker #(
    .N_BANKS(N_BANKS), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank)
);

// File: tb/sim_dram_cmd_sched.sv
module sim_dram_cmd_sched;
    import dcs_pkg::*;

    localparam int NB = 4, RW = 8, CW = 6;
    localparam int TRCD = 2, TRP = 3, TRAS = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NB-1:0]   req_valid = '0, req_write = '0;
    logic [NB*RW-1:0] req_row = '0;
    logic [NB*CW-1:0] req_col = '0;
    logic [NB-1:0]   req_ready;
    logic [2:0]      cmd_op;
    logic [1:0]      cmd_bank;
    logic [RW-1:0]   cmd_row;
    logic [CW-1:0]   cmd_col;

    always #2 clk = ~clk;

    dram_cmd_sched #(.N_BANKS(NB), .ROW_W(RW), .COL_W(CW),
                     .T_RCD(TRCD), .T_RP(TRP), .T_RAS(TRAS)) u0 (.*);

    int nchk = 0, nfail = 0, cyc = 0;

    typedef struct packed {
        logic [1:0]  bank;
        logic        wr;
        logic [7:0]  row;
        logic [5:0]  col;
        logic [1:0]  n;
        logic [8:0]  seq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 8'd5, 6'd1, 2'd2, {CMD_ACT, CMD_RD,  CMD_NOP}},
        '{2'd0, 1'b1, 8'd5, 6'd2, 2'd1, {CMD_WR,  CMD_NOP, CMD_NOP}},
        '{2'd0, 1'b0, 8'd9, 6'd3, 2'd3, {CMD_PRE, CMD_ACT, CMD_RD}},
        '{2'd2, 1'b1, 8'd1, 6'd4, 2'd2, {CMD_ACT, CMD_WR,  CMD_NOP}},
        '{2'd2, 1'b1, 8'd1, 6'd5, 2'd1, {CMD_WR,  CMD_NOP, CMD_NOP}},
        '{2'd2, 1'b0, 8'd3, 6'd6, 2'd3, {CMD_PRE, CMD_ACT, CMD_RD}}
    };

    // command log filled at each falling edge
    int         log_n = 0;
    logic [2:0] lg_op [8];
    logic [1:0] lg_bk [8];
    logic [7:0] lg_row [8];
    logic [5:0] lg_col [8];
    int         lg_t [8];
    int         last_act [4] = '{-100, -100, -100, -100};

    initial forever begin
        @(negedge clk);
        cyc++;
        if (cmd_op != 3'd0 && log_n < 8) begin
            lg_op[log_n] = cmd_op; lg_bk[log_n] = cmd_bank;
            lg_row[log_n] = cmd_row; lg_col[log_n] = cmd_col;
            lg_t[log_n] = cyc; log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic look_cmd(input string req, input int op, input int bk, input int fld);
        @(negedge clk);
        chk(cmd_op == 3'(op), req, "cmd_op", cmd_op, op);
        if (op != 0) chk(cmd_bank == 2'(bk), req, "cmd_bank", cmd_bank, bk);
        if (op == 1) chk(cmd_row == 8'(fld), req, "cmd_row", cmd_row, fld);
        if (op == 2 || op == 3) chk(cmd_col == 6'(fld), req, "cmd_col", cmd_col, fld);
    endtask

    task automatic send(input vec_t v);
        tick();
        log_n = 0;
        req_write[v.bank] = v.wr;
        req_row[v.bank*RW +: RW] = v.row;
        req_col[v.bank*CW +: CW] = v.col;
        req_valid[v.bank] = 1'b1;
        do @(negedge clk); while (!req_ready[v.bank]);
        tick();
        req_valid[v.bank] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state with no requests
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(cmd_op == 3'd0, "R10", "cmd_op after reset", cmd_op, 0);
            chk(req_ready == '0, "R10", "req_ready after reset", req_ready, 0);
        end

        // vector table: one transaction at a time on a single bank
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = (v.n == 2'd1) ? "R2" : (v.n == 2'd2) ? "R1" : "R3";
            send(v);
            chk(log_n == int'(v.n), tag, "command count", log_n, v.n);
            for (int k = 0; k < int'(v.n) && k < log_n; k++) begin
                logic [2:0] eop;
                eop = v.seq[8-3*k -: 3];
                chk(lg_op[k] == eop, tag, "command order", lg_op[k], eop);
                chk(lg_bk[k] == v.bank, "R11", "command bank", lg_bk[k], v.bank);
                if (eop == CMD_ACT) begin
                    chk(lg_row[k] == v.row, "R11", "activate row", lg_row[k], v.row);
                    if (k + 1 < log_n)
                        chk(lg_t[k+1] - lg_t[k] == TRCD, "R4", "act to access gap",
                            lg_t[k+1] - lg_t[k], TRCD);
                    last_act[v.bank] = lg_t[k];
                end
                if (eop == CMD_PRE) begin
                    chk(lg_t[k] - last_act[v.bank] >= TRAS, "R6", "act to pre gap",
                        lg_t[k] - last_act[v.bank], TRAS);
                    if (k + 1 < log_n)
                        chk(lg_t[k+1] - lg_t[k] == TRP, "R5", "pre to act gap",
                            lg_t[k+1] - lg_t[k], TRP);
                end
                if (eop == CMD_RD || eop == CMD_WR)
                    chk(lg_col[k] == v.col, "R11", "access column", lg_col[k], v.col);
            end
        end

        // directed: tie, timing holds, age over index
        repeat (3) tick();
        req_row[1*RW +: RW] = 8'd4; req_col[1*CW +: CW] = 6'd7; req_write[1] = 1'b0;
        req_row[3*RW +: RW] = 8'd6; req_col[3*CW +: CW] = 6'd8; req_write[3] = 1'b1;
        req_valid[1] = 1'b1; req_valid[3] = 1'b1;
        look_cmd("R8", 1, 1, 4);
        chk(req_ready == '0, "R9", "no ready on activate", req_ready, 0);
        tick(); look_cmd("R4", 1, 3, 6);
        tick(); look_cmd("R1", 2, 1, 7);
        chk(req_ready == 4'b0010, "R9", "ready with read", req_ready, 2);
        tick(); req_valid[1] = 1'b0;
        look_cmd("R4", 3, 3, 8);
        tick(); req_row[3*RW +: RW] = 8'd7;
        look_cmd("R6", 0, 0, 0);
        tick(); look_cmd("R6", 0, 0, 0);
        tick();
        req_row[0] = 1'b0;
        req_row[0*RW +: RW] = 8'd9; req_col[0*CW +: CW] = 6'd5; req_write[0] = 1'b0;
        req_valid[0] = 1'b1;
        look_cmd("R7", 4, 3, 0);
        tick(); look_cmd("R7", 2, 0, 5);
        chk(req_ready == 4'b0001, "R9", "ready with row hit", req_ready, 1);
        tick(); req_valid[0] = 1'b0;
        look_cmd("R5", 0, 0, 0);
        tick(); look_cmd("R5", 1, 3, 7);
        tick(); look_cmd("R4", 0, 0, 0);
        tick(); look_cmd("R3", 3, 3, 8);
        chk(req_ready == 4'b1000, "R9", "ready with write", req_ready, 8);
        tick(); req_valid[3] = 1'b0;
        look_cmd("R10", 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule